// File: doc/BRIEF.md
# Command-Framed SPI Register Slave

This block is an SPI slave in mode 3 (clock idles high, data sampled on the rising edge) that runs entirely on a fast system clock. Chip select, serial clock and data-in pass through synchronisers. Clock edges are detected on the system clock. Incoming bits are packed into bytes, most significant bit first.

Each chip-select frame opens with a command byte. Two write commands fill a 64-bit key register or a 32-bit block register with the bytes that follow, least significant byte first. Two start commands each raise a single-cycle strobe toward a cipher engine and set the direction bit. Two read commands send data back on the serial output during dummy bytes: either the engine's done flag or its 32-bit result. The cipher engine itself sits outside this block. It connects through the key, block, start, mode, done and result ports.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset the key and block registers are zero, both start strobes are low, the direction bit is 0 and the serial output is 0.
- R2: Bits are sampled on rising SCK edges while CS_n is low and grouped into bytes, first bit received = bit 7. The first complete byte of a frame is the command.
- R3: Command 0x01 stores the next 8 bytes into the key, the first into key[7:0] and the eighth into key[63:56]. The key changes at no other time.
- R4: Command 0x02 stores the next 4 bytes into the block, the first into block[7:0]. The block changes at no other time.
- R5: Command 0x03 produces exactly one single-cycle encrypt strobe and sets the direction bit to 0. Command 0x04 produces exactly one single-cycle decrypt strobe and sets it to 1. The direction bit changes only alongside a strobe.
- R6: Command 0x05 returns {7'b0, done} on the serial output during the byte that follows it.
- R7: Command 0x06 returns the 32-bit result over the next 4 bytes: result[7:0] first, each byte MSB first.
- R8: Raising CS_n discards any partial byte and clears the command state, so the next frame starts with a new command. A partial command byte causes no strobe.
- R9: Unknown command codes and bytes beyond a command's defined count change no register. The serial output is 0 during them and during the command byte itself.
- R10: The serial output changes only after a falling SCK edge or while CS_n is high. It holds steady through each high SCK phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the master, idles high |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the master |
| miso_o | output | 1 | Serial data to the master |
| key_o | output | 64 | Key register |
| block_o | output | 32 | Data block register |
| enc_start_o | output | 1 | One-cycle encrypt start strobe |
| dec_start_o | output | 1 | One-cycle decrypt start strobe |
| mode_o | output | 1 | Direction: 0 encrypt, 1 decrypt |
| done_i | input | 1 | Engine finished flag |
| result_i | input | 32 | Engine result word |

## Verification
The assertions rely on SCK half periods of at least four system clocks. Under that condition a byte completion always reaches the command logic before the next falling edge is detected, and no two strobes can fall in adjacent cycles. They also assume CS_n changes only while SCK is high. The bench drives SCK with four-clock phases, moves MOSI together with each falling edge, and toggles CS_n only with SCK held high and several clocks of margin on both sides.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic [7:0] {
    OP_KEY    = 8'h01,
    OP_BLOCK  = 8'h02,
    OP_ENC    = 8'h03,
    OP_DEC    = 8'h04,
    OP_STATUS = 8'h05,
    OP_RESULT = 8'h06
  } op_e;

  // Byte lane i of a wide word (lane 0 = least significant).
  function automatic logic [7:0] lane_of(input logic [63:0] v, input int unsigned i);
    return 8'(v >> (i * 8));
  endfunction

  // Next serial-out byte of a transfer, MSB leaves first.
  function automatic logic [7:0] shift_out(input logic [7:0] b);
    return {b[6:0], 1'b0};
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic mosi_s
);

  logic [STAGES:0]   sck_ff;
  logic [STAGES-1:0] csn_ff;
  logic [STAGES-1:0] mosi_ff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_ff  <= '1;
      csn_ff  <= '1;
      mosi_ff <= '0;
    end else begin
      sck_ff  <= {sck_ff[STAGES-1:0], sck_i};
      csn_ff  <= {csn_ff[STAGES-2:0], csn_i};
      mosi_ff <= {mosi_ff[STAGES-2:0], mosi_i};
    end
  end

  assign sck_rise  = sck_ff[STAGES-1] & ~sck_ff[STAGES];
  assign sck_fall  = ~sck_ff[STAGES-1] & sck_ff[STAGES];
  assign cs_active = ~csn_ff[STAGES-1];
  assign mosi_s    = mosi_ff[STAGES-1];

endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       sck_rise,
  input  logic       mosi_s,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic [2:0] bit_cnt
);

  logic [6:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q       <= '0;
      bit_cnt    <= '0;
      byte_valid <= 1'b0;
      byte_data  <= '0;
    end else if (!cs_active) begin
      sh_q       <= '0;
      bit_cnt    <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      if (sck_rise) begin
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_data  <= {sh_q, mosi_s};
          byte_valid <= 1'b1;
          sh_q       <= '0;
        end else begin
          sh_q <= {sh_q[5:0], mosi_s};
        end
      end
    end
  end

  AST_BYTE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(sck_rise)); // R2
  AST_BITCNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (bit_cnt == 3'd0 && !byte_valid)); // R8

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int KEY_W = 64,
  parameter int BLK_W = 32,
  parameter int RES_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic [2:0]       bit_cnt,
  input  logic             sck_fall,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i,
  output logic [KEY_W-1:0] key_o,
  output logic [BLK_W-1:0] block_o,
  output logic             enc_start_o,
  output logic             dec_start_o,
  output logic             mode_o,
  output logic             miso_o
);

  localparam int KEY_BYTES = KEY_W / 8;
  localparam int BLK_BYTES = BLK_W / 8;
  localparam int RES_BYTES = RES_W / 8;
  localparam int IDX_W     = $clog2(KEY_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(KEY_BYTES);

  logic [7:0]       cmd_q;
  logic             have_cmd_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tx_q;
  logic [7:0]       next_byte;

  // Named internal events.
  logic cmd_ev, data_ev, wr_key_ev, wr_blk_ev, tx_load_ev, tx_shift_ev;
  assign cmd_ev      = byte_valid && !have_cmd_q;
  assign data_ev     = byte_valid && have_cmd_q;
  assign wr_key_ev   = data_ev && (cmd_q == OP_KEY) && (idx_q < IDX_W'(KEY_BYTES));
  assign wr_blk_ev   = data_ev && (cmd_q == OP_BLOCK) && (idx_q < IDX_W'(BLK_BYTES));
  assign tx_load_ev  = cs_active && sck_fall && (bit_cnt == 3'd0);
  assign tx_shift_ev = cs_active && sck_fall && (bit_cnt != 3'd0);

  // Command state and byte index.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q      <= '0;
      have_cmd_q <= 1'b0;
      idx_q      <= '0;
    end else if (!cs_active) begin
      cmd_q      <= '0;
      have_cmd_q <= 1'b0;
      idx_q      <= '0;
    end else if (cmd_ev) begin
      cmd_q      <= byte_data;
      have_cmd_q <= 1'b1;
      idx_q      <= '0;
    end else if (data_ev && idx_q != IDX_MAX) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // Start strobes and direction.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_start_o <= 1'b0;
      dec_start_o <= 1'b0;
      mode_o      <= 1'b0;
    end else begin
      enc_start_o <= cmd_ev && (byte_data == OP_ENC);
      dec_start_o <= cmd_ev && (byte_data == OP_DEC);
      if (cmd_ev && byte_data == OP_ENC) mode_o <= 1'b0;
      else if (cmd_ev && byte_data == OP_DEC) mode_o <= 1'b1;
    end
  end

  // Byte-lane registers.
  for (genvar g = 0; g < KEY_BYTES; g++) begin : g_key_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) key_o[g*8 +: 8] <= '0;
      else if (wr_key_ev && idx_q == IDX_W'(g)) key_o[g*8 +: 8] <= byte_data;
    end
  end

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_blk_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) block_o[g*8 +: 8] <= '0;
      else if (wr_blk_ev && idx_q == IDX_W'(g)) block_o[g*8 +: 8] <= byte_data;
    end
  end

  // Byte the master reads next.
  always_comb begin
    next_byte = '0;
    if (have_cmd_q) begin
      if (cmd_q == OP_STATUS && idx_q == '0)
        next_byte = {7'b0, done_i};
      else if (cmd_q == OP_RESULT && idx_q < IDX_W'(RES_BYTES))
        next_byte = lane_of(64'(result_i), int'(idx_q));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else if (!cs_active) tx_q <= '0;
    else if (tx_load_ev) tx_q <= next_byte;
    else if (tx_shift_ev) tx_q <= shift_out(tx_q);
  end

  assign miso_o = tx_q[7];

  AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enc_start_o, dec_start_o})); // R5
  AST_START_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (enc_start_o || dec_start_o) |=> !(enc_start_o || dec_start_o)); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(enc_start_o || dec_start_o) |-> $stable(mode_o)); // R5
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_key_ev |=> $stable(key_o)); // R3
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_blk_ev |=> $stable(block_o)); // R4
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_MAX); // R9
  AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_active && !sck_fall) |=> $stable(miso_o)); // R10
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |=> (tx_q == 8'h00 && !have_cmd_q)); // R8

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int KEY_W       = 64,
  parameter int BLK_W       = 32,
  parameter int RES_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_i,
  input  logic             csn_i,
  input  logic             mosi_i,
  output logic             miso_o,
  output logic [KEY_W-1:0] key_o,
  output logic [BLK_W-1:0] block_o,
  output logic             enc_start_o,
  output logic             dec_start_o,
  output logic             mode_o,
  input  logic             done_i,
  input  logic [RES_W-1:0] result_i
);

  logic       sck_rise, sck_fall, cs_active, mosi_s;
  logic       byte_valid;
  logic [7:0] byte_data;
  logic [2:0] bit_cnt;

  spi_in_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .csn_i(csn_i), .mosi_i(mosi_i),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active), .mosi_s(mosi_s)
  );

  spi_byte_rx i_rx (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .sck_rise(sck_rise),
    .mosi_s(mosi_s), .byte_valid(byte_valid), .byte_data(byte_data), .bit_cnt(bit_cnt)
  );

  spi_cmd_ctrl #(.KEY_W(KEY_W), .BLK_W(BLK_W), .RES_W(RES_W)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .byte_valid(byte_valid),
    .byte_data(byte_data), .bit_cnt(bit_cnt), .sck_fall(sck_fall),
    .done_i(done_i), .result_i(result_i), .key_o(key_o), .block_o(block_o),
    .enc_start_o(enc_start_o), .dec_start_o(dec_start_o), .mode_o(mode_o),
    .miso_o(miso_o)
  );

endmodule

// File: tb/test_spi_cmd_slave.sv
module test_spi_cmd_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b1, csn = 1'b1, mosi = 1'b0;
  logic        miso;
  logic [63:0] key;
  logic [31:0] blk;
  logic        enc_st, dec_st, mode;
  logic        done = 1'b0;
  logic [31:0] result = '0;

  int checks = 0, fails = 0;
  int enc_cnt = 0, dec_cnt = 0, wide_err = 0, r10_err = 0;
  logic [7:0] tbuf [0:15];
  logic [7:0] rbuf [0:15];

  always #10 clk = ~clk;

  spi_cmd_slave i_spi_cmd_slave (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .key_o(key), .block_o(blk), .enc_start_o(enc_st),
    .dec_start_o(dec_st), .mode_o(mode), .done_i(done), .result_i(result)
  );

  // Cipher stand-in: rotate block halves and mix in one key half.
  int busy = 0;
  always @(negedge clk) begin
    if (enc_st || dec_st) begin
      done   <= 1'b0;
      busy   <= 300;
      result <= {blk[15:0], blk[31:16]} ^ (mode ? key[63:32] : key[31:0]);
    end else if (busy > 0) begin
      busy <= busy - 1;
      if (busy == 1) done <= 1'b1;
    end
  end

  // Strobe-width and serial-output timing monitors.
  logic enc_p = 1'b0, dec_p = 1'b0, miso_p = 1'b0;
  always @(negedge clk) begin
    if (enc_st && !enc_p) enc_cnt++;
    if (dec_st && !dec_p) dec_cnt++;
    if ((enc_st && enc_p) || (dec_st && dec_p)) wide_err++;
    if (rst_n && !csn && sck && miso !== miso_p) r10_err++;
    enc_p = enc_st; dec_p = dec_st; miso_p = miso;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame: n full bytes, then tail extra bits of byte n.
  task automatic xfer(input int n, input int tail);
    @(negedge clk) csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < n + ((tail > 0) ? 1 : 0); b++) begin
      int nb = (b < n) ? 8 : tail;
      rbuf[b] = '0;
      for (int i = 7; i >= 8 - nb; i--) begin
        sck = 1'b0; mosi = tbuf[b][i];
        repeat (4) @(negedge clk);
        rbuf[b][i] = miso;
        sck = 1'b1;
        repeat (4) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    csn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic write_block(input logic [31:0] v);
    tbuf[0] = 8'h02;
    for (int i = 0; i < 4; i++) tbuf[1+i] = v[i*8 +: 8];
    xfer(5, 0);
  endtask

  task automatic poll_done();
    for (int p = 0; p < 10; p++) begin
      tbuf[0] = 8'h05; tbuf[1] = 8'h00;
      xfer(2, 0);
      if (rbuf[1] == 8'h01) break;
      repeat (100) @(negedge clk);
    end
  endtask

  localparam logic [31:0] BLK_VEC [4] = '{32'h12345678, 32'hFFFF0000, 32'h80000001, 32'hA5C33C5A};
  localparam logic [63:0] KEY_V = 64'h0123456789ABCDEF;
  localparam logic [31:0] BLK_V = 32'hDEADBEEF;

  initial begin
    logic [31:0] exp_res;
    logic [7:0]  orv;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 key", key, 64'h0);
    chk("R1 block", 64'(blk), 64'h0);
    chk("R1 strobes/mode/miso", {enc_st, dec_st, mode, miso}, 64'h0);

    // Vector table: block writes, MSB-first bits, LSB-first bytes.
    for (int v = 0; v < 4; v++) begin
      write_block(BLK_VEC[v]);
      chk("R4 R2 block vector", 64'(blk), 64'(BLK_VEC[v]));
    end

    tbuf[0] = 8'h01;
    for (int i = 0; i < 8; i++) tbuf[1+i] = KEY_V[i*8 +: 8];
    xfer(9, 0);
    chk("R3 key write", key, KEY_V);
    write_block(BLK_V);
    chk("R4 block write", 64'(blk), 64'(BLK_V));

    // Encrypt.
    tbuf[0] = 8'h03; xfer(1, 0);
    chk("R5 enc count", 64'(enc_cnt), 64'd1);
    chk("R5 no dec", 64'(dec_cnt), 64'd0);
    chk("R5 mode enc", 64'(mode), 64'd0);

    tbuf[0] = 8'h05; tbuf[1] = 8'h00; xfer(2, 0);
    chk("R6 status busy", 64'(rbuf[1]), 64'h00);
    chk("R9 command byte miso zero", 64'(rbuf[0]), 64'h00);
    poll_done();
    chk("R6 status done", 64'(rbuf[1]), 64'h01);

    tbuf[0] = 8'h06;
    for (int i = 1; i < 7; i++) tbuf[i] = 8'h00;
    xfer(7, 0);
    exp_res = {BLK_V[15:0], BLK_V[31:16]} ^ KEY_V[31:0];
    chk("R7 enc result", 64'({rbuf[4], rbuf[3], rbuf[2], rbuf[1]}), 64'(exp_res));
    chk("R9 extra read bytes zero", 64'({rbuf[5], rbuf[6]}), 64'h0);

    // Decrypt.
    tbuf[0] = 8'h04; xfer(1, 0);
    chk("R5 dec count", 64'(dec_cnt), 64'd1);
    chk("R5 mode dec", 64'(mode), 64'd1);
    poll_done();
    tbuf[0] = 8'h06;
    for (int i = 1; i < 5; i++) tbuf[i] = 8'h00;
    xfer(5, 0);
    exp_res = {BLK_V[15:0], BLK_V[31:16]} ^ KEY_V[63:32];
    chk("R7 dec result", 64'({rbuf[4], rbuf[3], rbuf[2], rbuf[1]}), 64'(exp_res));

    // Aborted frames.
    tbuf[0] = 8'h02; tbuf[1] = 8'h5A; tbuf[2] = 8'hFF;
    xfer(2, 4);
    chk("R8 partial byte dropped", 64'(blk), 64'h00000000DEADBE5A);
    write_block(32'h44332211);
    chk("R8 new frame new command", 64'(blk), 64'h44332211);
    tbuf[0] = 8'h03; xfer(0, 4);
    chk("R8 partial command no strobe", 64'(enc_cnt), 64'd1);

    // Unknown command and surplus bytes.
    tbuf[0] = 8'h7E;
    for (int i = 1; i < 6; i++) tbuf[i] = 8'(i);
    xfer(6, 0);
    orv = '0;
    for (int i = 0; i < 6; i++) orv |= rbuf[i];
    chk("R9 unknown keeps block", 64'(blk), 64'h44332211);
    chk("R9 unknown keeps key", key, KEY_V);
    chk("R9 unknown miso zero", 64'(orv), 64'h0);
    tbuf[0] = 8'h02;
    for (int i = 1; i < 7; i++) tbuf[i] = 8'(8'hA0 + i);
    xfer(7, 0);
    chk("R9 surplus write bytes", 64'(blk), 64'h00000000A4A3A2A1);
    chk("R9 surplus keeps key", key, KEY_V);

    chk("R5 strobe width", 64'(wide_err), 64'd0);
    chk("R10 miso steady while SCK high", 64'(r10_err), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule